// File: doc/BRIEF.md
# Split-Section Ripple Counter

This block is a four-bit binary counter made of two sections that share no internal link. A lone toggle stage is advanced by one count input, and a three-stage divide-by-eight chain is advanced by a second count input. Every stage advances when its count input goes from high to low. Inside the chain, each stage after the first is advanced by the falling output of the stage below it, so the chain bits update one after another and not together. Because the sections are not joined, the wiring outside the block sets the mode. Routing the toggle stage's output back into the chain input makes a divide-by-16 counter with tap ratios 2, 4, 8 and 16. Driving only the chain input makes a divide-by-8 counter with tap ratios 2, 4 and 8, and leaves the lone stage free for other uses.

The count inputs are sampled on a free-running system clock. A registered falling-edge detector turns each sampled input edge into a one-cycle step, and each later chain stage is stepped by a detected fall of the stage below it. The ripple order is kept, with one clock of stagger per stage. A clear request is the AND of two request inputs. It empties every stage at once, asynchronously, and it blocks all counting. Its release is held back to the system clock. A separate synchronous active-low reset returns the whole block to its idle state.

Top module: `split_ripple_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `count_q` becomes 0 at that edge and stays 0 until the reset is released.
- R2: `count_q[0]` inverts once for each high-to-low transition of `toggle_in`. A low-to-high transition leaves it unchanged.
- R3: The chain value `count_q[3:1]` (bit 1 least significant) goes up by one for each high-to-low transition of `chain_in`, and wraps from 7 to 0.
- R4: The two sections are independent. `toggle_in` never changes `count_q[3:1]`, and `chain_in` never changes `count_q[0]`.
- R5: A stage driven by an input changes on the second rising clock edge after the first edge at which that input is sampled low. The input must have been sampled high on the edge before.
- R6: When only one of `clr_a` and `clr_b` is high, nothing is cleared and counting goes on as usual.
- R7: While `clr_a` and `clr_b` are both high, `count_q` is 0. The clear acts at once, without waiting for a clock edge.
- R8: Count-input transitions that happen while the clear is active are lost. `count_q` stays 0 for two clock edges after the clear is released and accepts new count edges after that.
- R9: With `count_q[0]` wired to `chain_in`, the block counts modulo 16 on `toggle_in` falling transitions, and `count_q` holds the binary count.
- R10: A chain stage above bit 1 changes one clock edge after the stage below it falls, so on a carry the chain bits change on consecutive edges, from bit 1 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| toggle_in | input | 1 | Count input of the lone toggle stage, active on falling transitions |
| chain_in | input | 1 | Count input of the three-stage chain, active on falling transitions |
| clr_a | input | 1 | First clear request; clears only together with `clr_b` |
| clr_b | input | 1 | Second clear request; clears only together with `clr_a` |
| count_q | output | CHAIN_BITS+1 | Bit 0 is the toggle stage; the bits above it are the chain, least significant first |

## Verification
The bench builds the block with its default parameters: a three-stage chain, a two-flop input synchronizer and a two-cycle clear release. With these values the chain wraps within eight pulses, and the wired four-bit mode completes a full modulo-16 cycle and more within twenty pulses. The short chain also lets a single carry from 3 to 4 show the one-cycle stagger across all three chain bits. The short release window lets the bench check, pulse by pulse, that count edges arriving during and just after a clear are lost while counting resumes shortly after.

// File: rtl/split_ripple_pkg.sv
// Package: split_ripple_pkg
// Default sizing shared by the split-section ripple counter and its checker.
// Assumes: every consumer imports these values as parameter defaults only.
package split_ripple_pkg;
    localparam int unsigned DEF_CHAIN_BITS  = 3;  // stages in the chained section
    localparam int unsigned DEF_SYNC_STAGES = 2;  // input synchronizer flops
    localparam int unsigned DEF_HOLD_CYCLES = 2;  // clock edges a clear is held after release
endpackage

// File: rtl/edge_fall_sense.sv
// Module: edge_fall_sense
// Brings an asynchronous count input into the clock domain and raises `fall`
// for exactly one cycle after a high-to-low transition has been seen.
// Assumes: the input stays at each level for at least one clock period, and
// SYNC_STAGES >= 1. `flush` empties the history asynchronously, so transitions
// seen while it is high are dropped.
module edge_fall_sense #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic din,
    output logic fall
);
    localparam int unsigned HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist;

    // Shift the sampled input through the synchronizer and one history flop.
    always_ff @(posedge clk or posedge flush) begin
        if (flush) begin
            hist <= '0;
        end else if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[HIST_W-2:0], din};
        end
    end

    // Falling edge: the older sample is high and the newer one is low.
    assign fall = hist[HIST_W-1] & ~hist[HIST_W-2];
endmodule

// File: rtl/clear_release_sync.sv
// Module: clear_release_sync
// Turns the combined clear request into a hold signal. The hold rises at once
// with the request and falls HOLD_CYCLES clock edges after the request drops.
// Assumes: HOLD_CYCLES >= 1; a synchronous reset also raises the hold.
module clear_release_sync #(
    parameter int unsigned HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_raw,
    output logic hold
);
    logic [HOLD_CYCLES-1:0] shreg;

    // Fill with ones on a clear or reset, then drain one position per edge.
    always_ff @(posedge clk or posedge clr_raw) begin
        if (clr_raw) begin
            shreg <= '1;
        end else if (!rst_n) begin
            shreg <= '1;
        end else begin
            shreg <= shreg << 1;
        end
    end

    assign hold = shreg[HOLD_CYCLES-1];
endmodule

// File: rtl/count_stage.sv
// Module: count_stage
// One divide-by-two stage. It inverts on each `step` pulse and reports a
// registered falling transition of its own output on `fell`, which the next
// stage uses as its step.
// Assumes: `clr` is an asynchronous, active-high hold that forces the stage
// and its history to zero.
module count_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic q,
    output logic fell
);
    logic q_d;

    // Toggle on step and remember the previous output for fall detection.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            q   <= 1'b0;
            q_d <= 1'b0;
        end else if (!rst_n) begin
            q   <= 1'b0;
            q_d <= 1'b0;
        end else begin
            if (step) begin
                q <= ~q;
            end
            q_d <= q;
        end
    end

    assign fell = q_d & ~q;
endmodule

// File: rtl/split_ripple_counter.sv
// Module: split_ripple_counter
// Two unconnected counting sections: a lone toggle stage on `toggle_in`, and a
// chain of CHAIN_BITS stages on `chain_in` in which each stage is stepped by
// the falling output of the one below it. The AND of the two clear requests
// clears everything at once; its release follows the system clock.
// Assumes: count inputs are slower than the system clock; external wiring
// of count_q[0] to chain_in selects the full-width mode.
module split_ripple_counter
    import split_ripple_pkg::*;
#(
    parameter int unsigned CHAIN_BITS  = DEF_CHAIN_BITS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                toggle_in,
    input  logic                chain_in,
    input  logic                clr_a,
    input  logic                clr_b,
    output logic [CHAIN_BITS:0] count_q
);
    localparam int unsigned OUT_W = CHAIN_BITS + 1;

    logic                  clr_raw;
    logic                  hold;
    logic                  step_lone;
    logic                  step_chain;
    logic                  lone_q;
    logic                  lone_fell;
    logic [CHAIN_BITS-1:0] chain_q;
    logic [CHAIN_BITS-1:0] chain_fell;
    logic [CHAIN_BITS-1:0] chain_step;

    // Clear request: both inputs must be high.
    assign clr_raw = clr_a & clr_b;

    clear_release_sync #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_raw (clr_raw),
        .hold    (hold)
    );

    edge_fall_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense_lone (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (hold),
        .din   (toggle_in),
        .fall  (step_lone)
    );

    edge_fall_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (hold),
        .din   (chain_in),
        .fall  (step_chain)
    );

    count_stage u_lone (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold),
        .step  (step_lone),
        .q     (lone_q),
        .fell  (lone_fell)
    );

    // Chain: stage 0 steps on the input fall, each later stage on the fall below.
    for (genvar gi = 0; gi < CHAIN_BITS; gi++) begin : g_chain
        if (gi == 0) begin : g_first
            assign chain_step[gi] = step_chain;
        end else begin : g_next
            assign chain_step[gi] = chain_fell[gi-1];
        end

        count_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (hold),
            .step  (chain_step[gi]),
            .q     (chain_q[gi]),
            .fell  (chain_fell[gi])
        );
    end

    // Output packing: lone stage at bit 0, chain above it.
    assign count_q = OUT_W'({chain_q, lone_q});

    // The lone stage's fall is not routed internally; mode is set by wiring.
    logic unused_lone_fell;
    assign unused_lone_fell = lone_fell;
endmodule

// File: rtl/split_ripple_counter_chk.sv
// Module: split_ripple_counter_chk
// Port-level temporal checks for split_ripple_counter, attached by bind.
// Assumes: count inputs and clear requests are stable across clock edges.
module split_ripple_counter_chk #(
    parameter int unsigned CHAIN_BITS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                toggle_in,
    input logic                chain_in,
    input logic                clr_a,
    input logic                clr_b,
    input logic [CHAIN_BITS:0] count_q
);
    logic clr_both;
    assign clr_both = clr_a & clr_b;

    // R7: an active clear leaves nothing set.
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_both |-> (count_q == '0));

    // R8: the edge after a sampled clear still shows an empty counter.
    a_r8_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_both) |-> (count_q == '0));

    // R2 / R5: the lone stage moves only after a sampled toggle_in fall.
    a_r2_lone_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count_q[0]) && !clr_both && !$past(clr_both))
        |-> ($past(toggle_in, 4) && !$past(toggle_in, 3)));

    // R3 / R4: the first chain stage moves only after a sampled chain_in fall.
    a_r3_chain_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count_q[1]) && !clr_both && !$past(clr_both))
        |-> ($past(chain_in, 4) && !$past(chain_in, 3)));

    // R10: each higher chain stage moves one edge after the stage below fell.
    for (genvar gk = 2; gk <= CHAIN_BITS; gk++) begin : g_ripple
        a_r10_ripple_order: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(count_q[gk]) && !clr_both && !$past(clr_both))
            |-> ($past(count_q[gk-1], 2) && !$past(count_q[gk-1])));
    end
endmodule

bind split_ripple_counter split_ripple_counter_chk #(.CHAIN_BITS(CHAIN_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .toggle_in (toggle_in),
    .chain_in  (chain_in),
    .clr_a     (clr_a),
    .clr_b     (clr_b),
    .count_q   (count_q)
);

// File: tb/split_ripple_counter_test.sv
`timescale 1ns/1ps
module split_ripple_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       toggle_drv = 1'b0;
    logic       chain_drv = 1'b0;
    logic       mode4 = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       chain_in;
    logic [3:0] count_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model.
    logic       m0 = 1'b0;
    logic [2:0] mc = 3'd0;

    typedef struct {
        string      req;
        logic [3:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];
    event sample_ev;

    always #2 clk = ~clk;  // 250 MHz

    assign chain_in = mode4 ? count_q[0] : chain_drv;

    split_ripple_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .toggle_in (toggle_drv),
        .chain_in  (chain_in),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .count_q   (count_q)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Monitor: pop each expected item and compare with the output.
    initial begin
        forever begin
            sb_item_t it;
            @(sample_ev);
            it = sb_q.pop_front();
            check(it.req, count_q, it.exp);
        end
    end

    // Driver side: queue an expectation and signal the monitor.
    task automatic expect_now(input string req, input logic [3:0] exp);
        sb_item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
        -> sample_ev;
        #0.5;
    endtask

    function automatic logic [3:0] model();
        return {mc, m0};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full pulse on toggle_in; the model follows the wiring mode.
    task automatic pulse_toggle(input bit upd);
        @(negedge clk); toggle_drv = 1'b1;
        wait_n(4);
        toggle_drv = 1'b0;
        wait_n(20);
        if (upd) begin
            if (mode4 && m0) mc = mc + 3'd1;
            m0 = ~m0;
        end
    endtask

    task automatic pulse_chain(input bit upd);
        @(negedge clk); chain_drv = 1'b1;
        wait_n(4);
        chain_drv = 1'b0;
        wait_n(20);
        if (upd) mc = mc + 3'd1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int c1, c2, c3;
        logic [3:0] prev;

        wait_n(5);
        expect_now("R1 reset state", 4'b0000);
        rst_n = 1'b1;
        wait_n(6);

        // R2: falling toggle transitions invert bit 0.
        for (int i = 0; i < 3; i++) begin
            pulse_toggle(1);
            expect_now("R2 toggle fall", model());
        end
        // R2: a rising transition alone changes nothing.
        @(negedge clk); toggle_drv = 1'b1;
        wait_n(12);
        expect_now("R2 rise ignored", model());
        toggle_drv = 1'b0;
        wait_n(20);
        m0 = ~m0;
        expect_now("R2 fall after rise", model());

        // R3 / R4: chain counts, lone bit untouched.
        while (mc != 3'd3) begin
            pulse_chain(1);
            expect_now("R3 R4 chain count", model());
        end

        // R10 / R5: a carry from 3 to 4 ripples upward one edge per stage.
        @(negedge clk); chain_drv = 1'b1;
        wait_n(4);
        chain_drv = 1'b0;
        c1 = -1; c2 = -1; c3 = -1;
        prev = count_q;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            if (c1 < 0 && count_q[1] != prev[1]) c1 = k;
            if (c2 < 0 && count_q[2] != prev[2]) c2 = k;
            if (c3 < 0 && count_q[3] != prev[3]) c3 = k;
        end
        mc = mc + 3'd1;
        wait_n(5);
        check("R5 first stage latency", 4'(c1), 4'd3);
        check("R10 bit2 one edge after bit1", 4'(c2 - c1), 4'd1);
        check("R10 bit3 one edge after bit2", 4'(c3 - c2), 4'd1);
        expect_now("R10 carry result", model());

        // R3: wrap 7 to 0.
        while (mc != 3'd0) begin
            pulse_chain(1);
            expect_now("R3 R4 chain wrap", model());
        end
        pulse_chain(1);
        expect_now("R3 after wrap", model());

        // R6: a single clear request does nothing.
        @(negedge clk); clr_a = 1'b1;
        wait_n(6);
        expect_now("R6 clr_a alone", model());
        pulse_toggle(1);
        expect_now("R6 count with clr_a alone", model());
        clr_a = 1'b0;
        @(negedge clk); clr_b = 1'b1;
        wait_n(6);
        pulse_chain(1);
        expect_now("R6 count with clr_b alone", model());
        clr_b = 1'b0;

        // R7: both high clears before any clock edge.
        @(negedge clk); clr_a = 1'b1; clr_b = 1'b1;
        #0.5;
        expect_now("R7 immediate clear", 4'b0000);
        m0 = 1'b0; mc = 3'd0;
        // R8: edges during the clear are lost.
        pulse_chain(0);
        pulse_toggle(0);
        expect_now("R8 edges during clear", 4'b0000);
        @(negedge clk); clr_a = 1'b0; clr_b = 1'b0;
        wait_n(8);
        expect_now("R8 after release", 4'b0000);
        pulse_chain(1);
        expect_now("R8 counting resumes", model());

        // R1: mid-count synchronous reset.
        @(negedge clk); rst_n = 1'b0;
        wait_n(4);
        expect_now("R1 mid-count reset", 4'b0000);
        m0 = 1'b0; mc = 3'd0;
        rst_n = 1'b1;
        wait_n(6);

        // R9: wired full-width mode.
        mode4 = 1'b1;
        wait_n(4);
        for (int i = 0; i < 20; i++) begin
            pulse_toggle(1);
            expect_now("R9 wired count", model());
        end

        // R7 in wired mode: mid-count clear, then resume.
        @(negedge clk); clr_a = 1'b1; clr_b = 1'b1;
        #0.5;
        expect_now("R7 wired clear", 4'b0000);
        m0 = 1'b0; mc = 3'd0;
        wait_n(4);
        clr_a = 1'b0; clr_b = 1'b0;
        wait_n(8);
        expect_now("R8 wired release", 4'b0000);
        for (int i = 0; i < 3; i++) begin
            pulse_toggle(1);
            expect_now("R9 wired resume", model());
        end

        wait_n(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule